// File: doc/BRIEF.md
# Complementary Dead-Time Pair Generator

This block sits behind a pair of PWM timer channels and drives their two output pins. When dead-time insertion is off, each pin carries its own channel's waveform. When it is on, the block ignores the second channel. It turns the first channel's waveform into two complementary drives for the high and low switches of an external power stage, with a programmable gap between them.

The gap is measured in PWM clock ticks. The PWM clock is the channel's divided clock, and it reaches the block as a one-cycle enable on the system clock. A leg turns off on the first clock after its source level drops. A leg turns on only after the source has asked for it through the programmed number of ticks. A source pulse shorter than the gap therefore never reaches its pin. Both pins are registered, so they have one system-clock cycle of latency in both modes.

Top module: `pwm_deadband_pair`

## Requirements
- R1: With `dz_en` low, `out_a` and `out_b` equal `src_a` and `src_b` as sampled on the previous clock edge.
- R2: With `dz_en` high, `out_a` becomes high only after `src_a` has been high on every edge since it went high and `dz_len` tick edges have been seen in that run. `out_b` behaves the same way for the inverse of `src_a`.
- R3: When the previous edge sampled `dz_en` high, `out_a` and `out_b` are never both high.
- R4: With `dz_len` equal to 0, `out_a` equals the previous `src_a` and `out_b` its inverse.
- R5: With `dz_en` high, a leg goes low on the first edge after its source level asks for low.
- R6: A source run shorter than `dz_len` ticks leaves the corresponding output low for the whole run.
- R7: With `dz_en` high, `src_b` has no effect on either output.
- R8: Only edges with `tick` high advance the dead-time count. Edges without a tick never complete the gap.
- R9: While `rst_n` is low, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | PWM clock enable, one cycle wide |
| dz_en | input | 1 | Dead-time insertion on |
| dz_len | input | CW | Gap length in PWM ticks |
| src_a | input | 1 | First channel PWM waveform |
| src_b | input | 1 | Second channel PWM waveform |
| out_a | output | 1 | First pin (high-side drive when enabled) |
| out_b | output | 1 | Second pin (low-side drive when enabled) |

## Verification
Random independent waveforms on both sources in pass-through mode separate plain forwarding from any pairing. A zero gap with random `src_b` shows pure complementing and shows that the second channel is ignored. Long square pulses with a tick on every cycle, and then a tick only every third cycle, separate counting ticks from counting system cycles. Pulses shorter than the gap show that sub-gap pulses are suppressed, and random gaps with random pulse lengths probe the edges where a run ends just as the count is reached.

// File: rtl/pwm_deadband_pair.sv
module pwm_deadband_pair #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          dz_en,
  input  logic [CW-1:0] dz_len,
  input  logic          src_a,
  input  logic          src_b,
  output logic          out_a,
  output logic          out_b
);

  logic [1:0] want;
  logic [1:0] drv;

  assign want = dz_en ? {~src_a, src_a} : {src_b, src_a};

  for (genvar g = 0; g < 2; g++) begin : g_leg
    logic          on_q;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        on_q <= 1'b0;
        cnt  <= '0;
      end else if (!dz_en) begin
        on_q <= want[g];
        cnt  <= '0;
      end else if (!want[g]) begin
        on_q <= 1'b0;
        cnt  <= '0;
      end else if (!on_q) begin
        if (cnt >= dz_len) on_q <= 1'b1;
        else if (tick)     cnt  <= cnt + 1'b1;
      end
    end

    assign drv[g] = on_q;
  end

  assign out_a = drv[0];
  assign out_b = drv[1];

  p_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dz_en) |-> !(out_a && out_b));

  p_passthru_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!dz_en) |-> (out_a == $past(src_a)) && (out_b == $past(src_b)));

  p_fall_now_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dz_en && !src_a) |-> !out_a);

  p_fall_now_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dz_en && src_a) |-> !out_b);

  p_rise_needs_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_a) && $past(dz_en)) |-> $past(src_a));

  p_zero_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dz_en && dz_len == '0) |-> (out_a == $past(src_a)) && (out_b == !$past(src_a)));

endmodule

// File: tb/pwm_deadband_pair_tb.sv
module pwm_deadband_pair_tb_top;
  localparam int CW = 8;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, dz_en = 1'b0;
  logic [CW-1:0] dz_len = '0;
  logic src_a = 1'b0, src_b = 1'b0;
  logic out_a, out_b;

  always #10 clk = ~clk;

  pwm_deadband_pair #(.CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .dz_en(dz_en), .dz_len(dz_len),
    .src_a(src_a), .src_b(src_b), .out_a(out_a), .out_b(out_b));

  typedef struct { logic a; logic b; logic en; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;
  int ra = 0, rb = 0;
  bit done = 0;

  task automatic step(input logic a, input logic b, input logic t,
                      input logic en, input int len, input string tag);
    exp_t e;
    @(negedge clk);
    src_a = a; src_b = b; tick = t; dz_en = en; dz_len = CW'(len);
    if (!en) begin
      e.a = a; e.b = b; ra = 0; rb = 0;
    end else begin
      e.a = a && (ra >= len);
      e.b = !a && (rb >= len);
      ra = a ? ra + int'(t) : 0;
      rb = !a ? rb + int'(t) : 0;
    end
    e.en = en; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic gap();
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, "R1");
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (out_a !== e.a || out_b !== e.b) begin
          fails++;
          $display("FAIL %s: out_a/out_b = %b%b, expected %b%b", e.tag, out_a, out_b, e.a, e.b);
        end
        if (e.en) begin
          checks++;
          if (out_a && out_b) begin
            fails++;
            $display("FAIL R3: both outputs high = %b%b, expected not 11", out_a, out_b);
          end
        end
      end
    end
  end

  initial begin : watchdog
    #3000000;
    fails++; checks++;
    $display("FAIL watchdog: run not finished, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    checks++;
    if (out_a !== 1'b0 || out_b !== 1'b0) begin
      fails++;
      $display("FAIL R9: reset outputs = %b%b, expected 00", out_a, out_b);
    end
    @(negedge clk); rst_n = 1'b1;
    // R1 pass-through
    for (int i = 0; i < 40; i++) step($urandom_range(1), $urandom_range(1), $urandom_range(1), 0, 3, "R1");
    gap();
    // R4 zero gap, R7 src_b random while enabled
    for (int i = 0; i < 40; i++) step($urandom_range(1), $urandom_range(1), $urandom_range(1), 1, 0, "R4_R7");
    gap();
    // R2 gap of 3 with a tick every cycle, long square pulses
    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < 10; i++) step(1, $urandom_range(1), 1, 1, 3, "R2");
      for (int i = 0; i < 10; i++) step(0, $urandom_range(1), 1, 1, 3, "R5");
    end
    gap();
    // R8 tick only every third cycle
    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < 12; i++) step(1, 0, (i % 3) == 2, 1, 2, "R8");
      for (int i = 0; i < 12; i++) step(0, 0, (i % 3) == 2, 1, 2, "R8");
    end
    gap();
    // R6 pulses shorter than the gap
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 3; i++) step(1, 0, 1, 1, 5, "R6");
      for (int i = 0; i < 3; i++) step(0, 0, 1, 1, 5, "R6");
    end
    gap();
    // R2 random gaps and run lengths
    for (int blk = 0; blk < 8; blk++) begin
      automatic int len = $urandom_range(4);
      for (int r = 0; r < 6; r++) begin
        automatic logic lvl = r[0];
        automatic int n = $urandom_range(7, 1);
        for (int i = 0; i < n; i++) step(lvl, $urandom_range(1), $urandom_range(1), 1, len, "R2");
      end
      gap();
    end
    wait (q.size() == 0);
    @(posedge clk); #2;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule